// File: doc/BRIEF.md
# Banked Dual-Port Word RAM with Same-Bank Arbitration

This block is the on-chip working memory of a signal-processing core. It holds a parameterised number of banks, each 1024 words of 16 bits. Two independent ports reach every bank. The instruction/coefficient port is read-only. The data port can read or write. When the two ports address different banks, or when only one port is active, both accesses finish in the same cycle with no wait-state.

When both ports address the same bank in the same cycle, the data port is served first. The instruction port sees `i_stall` for exactly one cycle and must hold its request and address. In the following cycle the instruction access is served ahead of everything else. If the data port lands on that same bank again in that cycle, `d_stall` goes high and the data port holds for one cycle. Read data appears on the cycle after an access is granted and then stays put until the next grant on that port.

Top module: `dpram_banks`

## Requirements
- R1: After reset, `i_rdata` and `d_rdata` read zero, and `i_stall` and `d_stall` are low.
- R2: A granted data-port write stores `d_wdata` at `d_addr`. A granted data-port read returns the stored word on `d_rdata` in the cycle after the grant.
- R3: A granted instruction-port read returns the stored word at `i_addr` on `i_rdata` in the cycle after the grant.
- R4: Requests from both ports to different banks raise no stall, and both are served in the same cycle.
- R5: If both ports request the same bank and the instruction port was not stalled in the previous cycle, the data access is served and `i_stall` is high for that cycle.
- R6: In the cycle after `i_stall`, the held instruction access is served with `i_stall` low. If the data port requests that same bank in that cycle, `d_stall` is high and the data access is served in the cycle after.
- R7: `i_stall` and `d_stall` are never high together, and `d_stall` is high only in the cycle that follows an `i_stall` cycle.
- R8: The bank is `addr[ADDR_W-1:10]` and the word within the bank is `addr[9:0]`. The same word offset in different banks holds separate storage.
- R9: A granted data-port write returns the word held at that address before the write on `d_rdata` in the next cycle (read-before-write).
- R10: A port's read data holds its value through cycles in which that port is not granted.
- R11: A stall is raised only when both ports request the same bank. A lone request never stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_req | input | 1 | Instruction/coefficient port read request |
| i_addr | input | ADDR_W | Instruction port word address (bank in upper bits) |
| i_rdata | output | WORD_W | Instruction port read data, one cycle after grant |
| i_stall | output | 1 | Instruction port must hold this cycle |
| d_req | input | 1 | Data port request |
| d_we | input | 1 | Data port write enable |
| d_addr | input | ADDR_W | Data port word address (bank in upper bits) |
| d_wdata | input | WORD_W | Data port write data |
| d_rdata | output | WORD_W | Data port read data (old word on a write), one cycle after grant |
| d_stall | output | 1 | Data port must hold this cycle |

## Verification
A wrong priority flag shows up first on the stall pins. A lost or stuck flag either drops the instruction port's guaranteed service or stalls the data port with no preceding instruction stall, and this is visible in the very cycle it goes wrong. A wrong bank decode or a wrong write path does not show at once. It appears only when a later grant reads that word back, one cycle after that grant, as a mismatched word on the read-data pins. The reference model therefore compares stalls every cycle and read data on every cycle in which the stored word is known.

// File: rtl/dpram_banks.sv
module dpram_banks #(
  parameter int NUM_BANKS = 2,
  parameter int WORD_W    = 16,
  parameter int BANK_AW   = 10
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           i_req,
  input  logic [BANK_AW+$clog2(NUM_BANKS)-1:0]           i_addr,
  output logic [WORD_W-1:0]                              i_rdata,
  output logic                                           i_stall,
  input  logic                                           d_req,
  input  logic                                           d_we,
  input  logic [BANK_AW+$clog2(NUM_BANKS)-1:0]           d_addr,
  input  logic [WORD_W-1:0]                              d_wdata,
  output logic [WORD_W-1:0]                              d_rdata,
  output logic                                           d_stall
);
  localparam int SEL_W  = $clog2(NUM_BANKS);
  localparam int ADDR_W = BANK_AW + SEL_W;
  localparam int DEPTH  = NUM_BANKS << BANK_AW;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              owed;

  wire [SEL_W-1:0] i_bank = i_addr[ADDR_W-1:BANK_AW];
  wire [SEL_W-1:0] d_bank = d_addr[ADDR_W-1:BANK_AW];
  wire             clash  = i_req & d_req & (i_bank == d_bank);

  assign i_stall = clash & ~owed;
  assign d_stall = clash & owed;

  wire i_go = i_req & ~i_stall;
  wire d_go = d_req & ~d_stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed <= 1'b0;
    else        owed <= i_stall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_rdata <= '0;
      d_rdata <= '0;
    end else begin
      if (i_go) i_rdata <= mem[i_addr];
      if (d_go) d_rdata <= mem[d_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (d_go && d_we) mem[d_addr] <= d_wdata;
  end

  assert_one_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    i_stall |=> !i_stall);
  assert_stalls_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({i_stall, d_stall}));
  assert_dstall_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !i_stall |=> !d_stall);
  assert_stall_needs_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (i_stall || d_stall) |-> (i_req && d_req && i_addr[ADDR_W-1:BANK_AW] == d_addr[ADDR_W-1:BANK_AW]));
  assert_data_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (i_stall && !d_we) |=> !$stable(d_rdata) || d_rdata == $past(mem[d_addr]));
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !i_req |=> $stable(i_rdata));
endmodule

// File: tb/test_dpram_banks.sv
`timescale 1ns/1ps
module test_dpram_banks;
  localparam int AW = 11;
  logic clk = 0, rst_n = 0;
  logic i_req = 0, d_req = 0, d_we = 0;
  logic [AW-1:0] i_addr = '0, d_addr = '0;
  logic [15:0] d_wdata = '0;
  logic [15:0] i_rdata, d_rdata;
  logic i_stall, d_stall;

  dpram_banks i_dpram_banks (.clk(clk), .rst_n(rst_n), .i_req(i_req), .i_addr(i_addr),
    .i_rdata(i_rdata), .i_stall(i_stall), .d_req(d_req), .d_we(d_we), .d_addr(d_addr),
    .d_wdata(d_wdata), .d_rdata(d_rdata), .d_stall(d_stall));

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  logic [15:0] mdl [int];
  logic [15:0] exp_i = 0, exp_d = 0;
  bit ki = 1, kd = 1, owed = 0;
  bit exp_is = 0, exp_ds = 0;

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit ir, input int ia, input bit dr, input bit dw, input int da,
                      input logic [15:0] wd, input string tag);
    bit clash, ig, dg;
    @(negedge clk);
    i_req = ir; i_addr = AW'(ia); d_req = dr; d_we = dw; d_addr = AW'(da); d_wdata = wd;
    #1;
    clash  = ir && dr && ((ia >> 10) == (da >> 10));
    exp_is = clash && !owed;
    exp_ds = clash && owed;
    chk(tag, "i_stall", {15'd0, i_stall}, {15'd0, exp_is});
    chk(tag, "d_stall", {15'd0, d_stall}, {15'd0, exp_ds});
    if (ki) chk(tag, "i_rdata", i_rdata, exp_i);
    if (kd) chk(tag, "d_rdata", d_rdata, exp_d);
    ig = ir && !exp_is;
    dg = dr && !exp_ds;
    if (ig) begin ki = mdl.exists(ia); if (ki) exp_i = mdl[ia]; end
    if (dg) begin
      kd = mdl.exists(da); if (kd) exp_d = mdl[da];
      if (dw) mdl[da] = wd;
    end
    owed = exp_is;
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 16'h0, tag);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int ia, da;
    bit ir, dr, dw;
    logic [15:0] wd;
    #9; rst_n = 1;
    @(negedge clk); #1;
    chk("R1", "i_rdata", i_rdata, 16'h0);
    chk("R1", "d_rdata", d_rdata, 16'h0);
    chk("R1", "stalls", {14'd0, i_stall, d_stall}, 16'h0);
    // R8: same offset, two banks
    step(0, 0, 1, 1, 5, 16'hAAAA, "R2");
    step(0, 0, 1, 1, 1024 + 5, 16'hBBBB, "R8");
    step(0, 0, 1, 0, 5, 16'h0, "R2");
    step(0, 0, 1, 0, 1024 + 5, 16'h0, "R8");
    idle("R8");
    step(1, 5, 0, 0, 0, 16'h0, "R3");
    step(1, 1024 + 5, 0, 0, 0, 16'h0, "R3");
    idle("R10");
    idle("R10");
    // R4: both ports, different banks
    step(1, 5, 1, 1, 1024 + 7, 16'h1234, "R4");
    step(1, 1024 + 7, 1, 0, 5, 16'h0, "R4");
    idle("R4");
    // R5/R6: conflict, then data port collides again while instruction is owed
    step(1, 5, 1, 1, 9, 16'h5555, "R5");
    step(1, 5, 1, 0, 9, 16'h0, "R6");
    step(0, 0, 1, 0, 9, 16'h0, "R6");
    idle("R7");
    // R11: lone requests never stall
    step(1, 9, 0, 0, 0, 16'h0, "R11");
    step(0, 0, 1, 0, 9, 16'h0, "R11");
    // R9: read-before-write on the data port
    step(0, 0, 1, 1, 5, 16'hC0DE, "R9");
    step(0, 0, 1, 1, 5, 16'hBEEF, "R9");
    idle("R9");
    // mixed traffic honouring the hold rule
    ir = 0; dr = 0; dw = 0; ia = 0; da = 0; wd = 0;
    for (int n = 0; n < 600; n++) begin
      if (!exp_is) begin
        ir = $urandom_range(0, 3) != 0;
        ia = ($urandom_range(0, 1) << 10) | $urandom_range(0, 3);
      end
      if (!exp_ds) begin
        dr = $urandom_range(0, 3) != 0;
        dw = $urandom_range(0, 1) == 1;
        da = ($urandom_range(0, 1) << 10) | $urandom_range(0, 3);
        wd = 16'($urandom);
      end
      step(ir, ia, dr, dw, da, wd, "R7");
    end
    idle("R10");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule